// File: doc/BRIEF.md
# Bus Initiator Latency Timer

This block bounds how long a bus initiator may hold the shared bus during a burst. Software programs an 8-bit tenure limit, counted in bus clocks. At the start of each transaction the initiator raises a one-cycle start strobe. The block then captures that limit and counts clocks from zero.

Reaching the limit is not enough on its own to cut the burst short. The block also watches the arbiter's grant. Only once the limit has been reached and grant has been withdrawn does it raise a registered request, asking the initiator sequencer to make the next data phase its last.

The request stays up until the sequencer reports that the transaction is over. That report also clears and halts the count until the next start.

Top module: `pci_lat_timer`

## Requirements
- R1: After reset, `lt_count` is 0 and both `lt_expired` and `burst_stop` are 0.
- R2: A clock edge that samples `frame_start` high captures `lt_value` as the limit for the new transaction, sets `lt_count` to 0 and clears `burst_stop`. If the same edge also samples `txn_end` high, the start takes priority.
- R3: Let edge 0 be the edge that samples `frame_start`. After edge n of that transaction, `lt_count` equals min(n, limit), and `lt_expired` is 1 exactly when n >= limit.
- R4: With a limit of 0, `lt_expired` is already 1 after edge 0.
- R5: `burst_stop` rises after the first edge that samples both `lt_expired` high and `gnt` low. With the grant removed from cycle D onward, `burst_stop` is 1 after edge n exactly when n >= max(limit, D) + 1.
- R6: While `gnt` stays high, expiry does not raise `burst_stop`, and the transaction continues.
- R7: Once raised, `burst_stop` stays 1 until an edge samples `txn_end` or `frame_start`, even if `gnt` returns high.
- R8: The count saturates at the limit and never wraps, including a limit of 255.
- R9: An edge that samples `txn_end` (without `frame_start`) clears `lt_count`, `lt_expired` and `burst_stop`. The count then stays 0 until the next start.
- R10: Changes to `lt_value` during a transaction have no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_value | input | 8 | Programmed tenure limit in bus clocks |
| frame_start | input | 1 | One-cycle strobe: this device drives FRAME as initiator |
| gnt | input | 1 | Bus grant from the arbiter, active high |
| txn_end | input | 1 | Transaction finished or initiator returned to idle |
| burst_stop | output | 1 | Request to end the burst at the next data phase |
| lt_expired | output | 1 | Limit reached in the current transaction |
| lt_count | output | 8 | Clocks elapsed in the current transaction, saturated |

## Verification
The assertions assume the following about the inputs:
- `frame_start` is a single-cycle strobe.
- `txn_end` arrives only to close a transaction that is running.
- `gnt` may change in any cycle.

The stimulus drives all inputs on the falling edge and keeps within these limits. Each transaction opens with a single start pulse and is closed by exactly one `txn_end` pulse. One directed case places a start and an end in the same cycle, to exercise the priority rule.

Grant is swept arbitrarily across every cycle offset, both before and after expiry.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic {
        CUT_IDLE = 1'b0,
        CUT_REQ  = 1'b1
    } cut_state_e;

    typedef struct packed {
        cut_state_e st;
    } cut_regs_t;

endpackage

// File: rtl/lt_counter.sv
module lt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             start,
    input  logic             finish,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.active = 1'b1;
            r_d.limit  = limit_in;
            r_d.cnt    = '0;
        end else if (finish) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else if (r_q.active && (r_q.cnt < r_q.limit)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count   = r_q.cnt;
    assign expired = r_q.active && (r_q.cnt >= r_q.limit);
endmodule

// File: rtl/lt_cut_ctl.sv
module lt_cut_ctl
    import lt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    input  logic expired,
    input  logic gnt,
    output logic cut
);
    cut_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start || finish) begin
            r_d.st = CUT_IDLE;
        end else if (expired && !gnt) begin
            r_d.st = CUT_REQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= CUT_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cut = (r_q.st == CUT_REQ);
endmodule

// File: rtl/pci_lat_timer.sv
module pci_lat_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lt_value,
    input  logic             frame_start,
    input  logic             gnt,
    input  logic             txn_end,
    output logic             burst_stop,
    output logic             lt_expired,
    output logic [CNT_W-1:0] lt_count
);
    logic exp_w;

    lt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_in (lt_value),
        .start    (frame_start),
        .finish   (txn_end),
        .count    (lt_count),
        .expired  (exp_w)
    );

    lt_cut_ctl u_cut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frame_start),
        .finish  (txn_end),
        .expired (exp_w),
        .gnt     (gnt),
        .cut     (burst_stop)
    );

    assign lt_expired = exp_w;
endmodule

// File: rtl/pci_lat_timer_chk.sv
module pci_lat_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] lt_value,
    input logic             frame_start,
    input logic             gnt,
    input logic             txn_end,
    input logic             burst_stop,
    input logic             lt_expired,
    input logic [CNT_W-1:0] lt_count
);
    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (lt_count == '0) && !burst_stop);

    // R9
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && !frame_start) |=> (lt_count == '0) && !lt_expired && !burst_stop);

    // R5
    cut_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_expired && !gnt && !txn_end && !frame_start) |=> burst_stop);

    // R6
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_stop && gnt) |=> !burst_stop);

    // R7
    cut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !txn_end && !frame_start) |=> burst_stop);

    // R7
    cut_needs_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_stop |-> lt_expired);

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_expired && !txn_end && !frame_start) |=> $stable(lt_count) && lt_expired);
endmodule

bind pci_lat_timer pci_lat_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pci_lat_timer_bench.sv
module pci_lat_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] lt_value;
    logic       frame_start;
    logic       gnt;
    logic       txn_end;
    logic       burst_stop;
    logic       lt_expired;
    logic [7:0] lt_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pci_lat_timer u_pci_lat_timer (
        .clk(clk), .rst_n(rst_n), .lt_value(lt_value),
        .frame_start(frame_start), .gnt(gnt), .txn_end(txn_end),
        .burst_stop(burst_stop), .lt_expired(lt_expired), .lt_count(lt_count)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] c_e,
                       input logic x_e, input logic s_e);
        n_chk++;
        if (lt_count !== c_e || lt_expired !== x_e || burst_stop !== s_e) begin
            n_fail++;
            $display("FAIL %s: got cnt=%0d exp=%b stop=%b, want cnt=%0d exp=%b stop=%b",
                     req, lt_count, lt_expired, burst_stop, c_e, x_e, s_e);
        end
    endtask

    // One transaction: limit L, grant withdrawn from cycle D onward.
    task automatic run_txn(input int L, input int D);
        int last;
        last = ((L > D) ? L : D) + 3;
        lt_value = 8'(L); frame_start = 1'b1; gnt = 1'b1;
        step();
        frame_start = 1'b0;
        for (int n = 0; n <= last; n++) begin
            lt_value = 8'(~L);                 // R10: ignored mid-transaction
            chk(n == 0 ? "R2" : (L == 0 ? "R4" : "R3/R5/R8"),
                8'((n < L) ? n : L), (n >= L),
                (n >= ((L > D) ? L : D) + 1));
            gnt = !(n >= D);                   // R6: high before D
            step();
        end
        txn_end = 1'b1; gnt = 1'b1;
        step();
        txn_end = 1'b0;
        chk("R9", 8'd0, 1'b0, 1'b0);
        step();
        chk("R9", 8'd0, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; lt_value = 8'd0; frame_start = 1'b0; gnt = 1'b1; txn_end = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1", 8'd0, 1'b0, 1'b0);

        for (int L = 0; L <= 6; L++)
            for (int D = 0; D <= L + 3; D++)
                run_txn(L, D);
        run_txn(255, 0);
        run_txn(255, 260);

        // R7: grant comes back after the cut request; request holds
        lt_value = 8'd2; frame_start = 1'b1; gnt = 1'b0;
        step();
        frame_start = 1'b0;
        repeat (3) step();
        chk("R7", 8'd2, 1'b1, 1'b1);
        gnt = 1'b1;
        repeat (3) step();
        chk("R7", 8'd2, 1'b1, 1'b1);

        // R2: start and end in the same cycle, start wins
        lt_value = 8'd3; frame_start = 1'b1; txn_end = 1'b1;
        step();
        frame_start = 1'b0; txn_end = 1'b0;
        chk("R2", 8'd0, 1'b0, 1'b0);
        step();
        chk("R2", 8'd1, 1'b0, 1'b0);
        txn_end = 1'b1;
        step();
        txn_end = 1'b0;
        chk("R9", 8'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule